// File: doc/BRIEF.md
# Strobe-Driven Word Buffer with Flow-Through

This block is a first-in first-out store of 9-bit words. Its depth is a parameter that may be 256, 512 or 1024. A writer and a reader each own an active-low strobe. A word is taken, or released, when its strobe returns high. Both strobes, and an active-low retransmit strobe, pass through a clock-domain synchroniser. Their low-to-high transitions are then detected on the system clock, so each strobe takes effect a fixed number of clock edges after it rises.

The reader sees the oldest stored word on `dout` while its strobe is held low. An output-enable signal stands in for a three-state bus: it is high only while the synchronised read strobe is low and the buffer holds data. The block provides three flags, empty, full and more-than-half-full, all driven from registers. Two corner cases are defined. Writing into an empty buffer while the read strobe is already low presents the new word at once (read flow-through). Reading from a full buffer while the write strobe is already low lets the pending write land when that strobe rises (write flow-through).

Top module: `strobe_fifo`

## Requirements
- R1: Words leave the buffer in the order they were written. A write takes effect on the third rising clock edge after `wr_n` goes from low to high, and it stores the value of `din` held at that edge.
- R2: `rd_oe` is high exactly when the synchronised `rd_n` is low and the buffer is not empty. While `rd_oe` is high, `dout` equals the oldest stored word.
- R3: `empty` is high exactly when the occupancy is zero, and `empty` and `full` are never high together.
- R4: `full` is high exactly when the occupancy equals DEPTH. A write strobe that completes while the buffer is full is ignored and leaves the stored words unchanged.
- R5: `half_full` is high exactly when the occupancy is greater than DEPTH/2.
- R6: With `rd_n` held low, a write into an empty buffer drives `rd_oe` high and puts that word on `dout`. Raising `rd_n` then consumes the word and returns `empty` to high.
- R7: With `wr_n` held low, a read from a full buffer drops `full`. Raising `wr_n` afterwards stores the pending word and raises `full` again.
- R8: When a write completion and a read completion are detected on the same clock edge and neither is blocked, both take effect and the occupancy is unchanged. When the buffer is full at that edge, only the read takes effect.
- R9: A low-to-high transition of `rt_n` moves the read position back to the first location written since reset. The stored words and the write position are unchanged, and the flags follow the new occupancy. A read completing on the same edge is dropped.
- R10: While `rst_n` is low, `empty` is high and `full`, `half_full` and `rd_oe` are low. After reset, both positions start at the first location.
- R11: A read strobe that completes while the buffer is empty is ignored, and the next word written is the next word read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe; a word is stored on its rising transition |
| rd_n | input | 1 | Active-low read strobe; a word is consumed on its rising transition |
| rt_n | input | 1 | Active-low retransmit strobe; acts on its rising transition |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Oldest stored word |
| rd_oe | output | 1 | Read output enable (bus-driven indication) |
| empty | output | 1 | Buffer holds no words |
| full | output | 1 | Buffer holds DEPTH words |
| half_full | output | 1 | Occupancy above DEPTH/2 |

## Verification
The bench builds the block with DEPTH of 256 and two synchroniser stages. This keeps a complete fill and drain short enough to repeat: the buffer reaches full, crosses the half-full boundary at 129 words in both directions, and goes through the write flow-through case at the full boundary. With a small depth, retransmit can also be exercised before the write position wraps. At that depth, the reference queue in the bench knows which word the rewound read position must return.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int unsigned WORD_W = 9;

    // Pointer movement chosen in a cycle: {write, read}
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_BOTH  = 2'b11
    } op_e;

endpackage

// File: rtl/sfifo_strobe_sync.sv
module sfifo_strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic level,
    output logic rise
);
    localparam int unsigned CW = STAGES + 1;

    logic [CW-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CW-2:0], strobe_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    // level is the synchronised strobe; rise marks low-to-high
    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned WIDTH = 9,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ev,
    input  logic          rd_ev,
    input  logic          rt_ev,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          empty,
    output logic          full,
    output logic          half_full,
    output logic [PW-1:0] occupancy
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic          empty;
        logic          full;
        logic          half;
    } ctrl_t;

    ctrl_t         st_d, st_q;
    op_e           op;
    logic [PW-1:0] cnt_d;

    always_comb begin
        st_d = st_q;
        op   = op_e'({wr_ev & ~st_q.full, rd_ev & ~st_q.empty & ~rt_ev});
        unique case (op)
            OP_WRITE: st_d.wp = st_q.wp + 1'b1;
            OP_READ:  st_d.rp = st_q.rp + 1'b1;
            OP_BOTH: begin
                st_d.wp = st_q.wp + 1'b1;
                st_d.rp = st_q.rp + 1'b1;
            end
            default: ;
        endcase
        if (rt_ev) st_d.rp = '0;
        cnt_d      = st_d.wp - st_d.rp;
        st_d.empty = (cnt_d == '0);
        st_d.full  = (cnt_d == FULL_CNT);
        st_d.half  = (cnt_d > HALF_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{wp: '0, rp: '0, empty: 1'b1, full: 1'b0, half: 1'b0};
        else        st_q <= st_d;
    end

    assign wr_en     = op[1];
    assign wr_addr   = st_q.wp[AW-1:0];
    assign rd_addr   = st_q.rp[AW-1:0];
    assign empty     = st_q.empty;
    assign full      = st_q.full;
    assign half_full = st_q.half;
    assign occupancy = st_q.wp - st_q.rp;
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int unsigned DEPTH       = 256,
    parameter int unsigned WIDTH       = sfifo_pkg::WORD_W,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rt_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             rd_oe,
    output logic             empty,
    output logic             full,
    output logic             half_full
);
    localparam int unsigned NSTROBE = 3;

    logic [NSTROBE-1:0] strobe_in, strobe_lvl, strobe_rise;
    logic               wr_rise, rd_rise, rt_rise;
    logic               wr_en;
    logic [AW-1:0]      wr_addr, rd_addr;
    logic [PW-1:0]      occupancy;
    logic               unused_lvl;

    assign strobe_in = {rt_n, rd_n, wr_n};

    for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
        sfifo_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (strobe_in[g]),
            .level    (strobe_lvl[g]),
            .rise     (strobe_rise[g])
        );
    end

    assign wr_rise    = strobe_rise[0];
    assign rd_rise    = strobe_rise[1];
    assign rt_rise    = strobe_rise[2];
    assign unused_lvl = strobe_lvl[0] ^ strobe_lvl[2];

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ev     (wr_rise),
        .rd_ev     (rd_rise),
        .rt_ev     (rt_rise),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .empty     (empty),
        .full      (full),
        .half_full (half_full),
        .occupancy (occupancy)
    );

    sfifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_data (dout)
    );

    // bus driven while the synchronised read strobe is low and data exists
    assign rd_oe = ~strobe_lvl[1] & ~empty;
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned PW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          empty,
    input logic          full,
    input logic          half_full,
    input logic          rd_oe,
    input logic          wr_ev,
    input logic          rd_ev,
    input logic          rt_ev,
    input logic [PW-1:0] occupancy
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

    assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    assert_full_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> occupancy == FULL_CNT);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_ev && !rt_ev) |=> (full && $stable(occupancy)));

    assert_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        half_full |-> occupancy > HALF_CNT);

    assert_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> !empty);

    assert_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev && rd_ev && !full && !empty && !rt_ev) |=> $stable(occupancy));

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_ev && !rt_ev) |=> (empty && occupancy == '0));
endmodule

bind strobe_fifo sfifo_checker #(.DEPTH(DEPTH)) u_sfifo_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .empty     (empty),
    .full      (full),
    .half_full (half_full),
    .rd_oe     (rd_oe),
    .wr_ev     (wr_rise),
    .rd_ev     (rd_rise),
    .rt_ev     (rt_rise),
    .occupancy (occupancy)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
    localparam int DEPTH = 256;
    localparam int W     = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         rd_oe, empty, full, half_full;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    strobe_fifo #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u_strobe_fifo (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .rd_oe(rd_oe), .empty(empty),
        .full(full), .half_full(half_full)
    );

    // ---------------- behavioural reference ----------------
    logic [W-1:0] hist[$];
    int           ridx;
    bit           w1, w2, w3, r1, r2, r3, t1, t2, t3;

    function automatic int occ();
        return hist.size() - ridx;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            ridx = 0;
            {w1, w2, w3, r1, r2, r3, t1, t2, t3} = '1;
        end else begin
            bit ew, er, et, was_full, was_empty;
            ew = w2 && !w3;
            er = r2 && !r3;
            et = t2 && !t3;
            was_full  = (occ() == DEPTH);
            was_empty = (occ() == 0);
            if (ew && !was_full) hist.push_back(din);
            if (et) ridx = 0;
            else if (er && !was_empty) ridx++;
            w3 = w2; w2 = w1; w1 = wr_n;
            r3 = r2; r2 = r1; r1 = rd_n;
            t3 = t2; t2 = t1; t1 = rt_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare against the reference on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_oe;
            chk(empty == (occ() == 0), "R3 empty", empty, occ() == 0);
            chk(full == (occ() == DEPTH), "R4 full", full, occ() == DEPTH);
            chk(half_full == (occ() > DEPTH / 2), "R5 half_full", half_full, occ() > DEPTH / 2);
            exp_oe = (r2 == 1'b0) && (occ() > 0);
            chk(rd_oe == exp_oe, "R2 rd_oe", rd_oe, exp_oe);
            if (exp_oe && rd_oe && ridx < hist.size())
                chk(dout == hist[ridx], "R1 dout order", dout, hist[ridx]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_word(input logic [W-1:0] d);
        @(negedge clk); din = d; wr_n = 1'b0;
        idle(2);
        wr_n = 1'b1;
        idle(4);
    endtask

    task automatic rd_word(output logic [W-1:0] d);
        @(negedge clk); rd_n = 1'b0;
        idle(2);
        d = dout;
        rd_n = 1'b1;
        idle(4);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        idle(2);
        chk(empty == 1'b1, "R10 empty in reset", empty, 1);
        chk(full == 1'b0 && half_full == 1'b0, "R10 full/half in reset", full | half_full, 0);
        chk(rd_oe == 1'b0, "R10 rd_oe in reset", rd_oe, 0);
        rst_n = 1'b1;
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got;
        do_reset();

        // R1: simple order
        wr_word(9'h101); wr_word(9'h0F2); wr_word(9'h033);
        rd_word(got); chk(got == 9'h101, "R1 first word", got, 9'h101);
        rd_word(got); chk(got == 9'h0F2, "R1 second word", got, 9'h0F2);
        rd_word(got); chk(got == 9'h033, "R1 third word", got, 9'h033);
        chk(empty == 1'b1, "R3 empty after drain", empty, 1);

        // R11: read while empty ignored
        rd_word(got);
        chk(empty == 1'b1, "R11 still empty", empty, 1);
        wr_word(9'h077);
        rd_word(got); chk(got == 9'h077, "R11 next written is next read", got, 9'h077);

        // R6: read flow-through
        do_reset();
        @(negedge clk); rd_n = 1'b0;
        idle(3);
        chk(rd_oe == 1'b0, "R6 no enable while empty", rd_oe, 0);
        wr_word(9'h1A5);
        chk(rd_oe == 1'b1, "R6 enable after write", rd_oe, 1);
        chk(dout == 9'h1A5, "R6 word on bus", dout, 9'h1A5);
        chk(empty == 1'b0, "R6 empty dropped", empty, 0);
        rd_n = 1'b1;
        idle(4);
        chk(empty == 1'b1, "R6 empty again", empty, 1);
        chk(rd_oe == 1'b0, "R6 bus released", rd_oe, 0);

        // R4, R5: fill
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(W'(i));
            if (i == DEPTH / 2 - 1)
                chk(half_full == 1'b0, "R5 not above half at DEPTH/2", half_full, 0);
            if (i == DEPTH / 2)
                chk(half_full == 1'b1, "R5 above half at DEPTH/2+1", half_full, 1);
        end
        chk(full == 1'b1, "R4 full after DEPTH writes", full, 1);
        wr_word(9'h1FF);
        chk(full == 1'b1, "R4 write while full ignored", full, 1);

        // R7: write flow-through
        @(negedge clk); din = 9'h0AA; wr_n = 1'b0;
        rd_word(got);
        chk(got == 9'h000, "R7 read from full", got, 0);
        chk(full == 1'b0, "R7 full dropped", full, 0);
        wr_n = 1'b1;
        idle(4);
        chk(full == 1'b1, "R7 full again", full, 1);
        for (int i = 1; i < DEPTH; i++) begin
            rd_word(got);
            if (i == 1) chk(got == 9'h001, "R4 ignored word absent", got, 1);
        end
        rd_word(got);
        chk(got == 9'h0AA, "R7 pending word stored", got, 9'h0AA);
        chk(empty == 1'b1, "R3 empty after full drain", empty, 1);

        // R8: simultaneous completions
        do_reset();
        wr_word(9'h011); wr_word(9'h022); wr_word(9'h033);
        @(negedge clk); din = 9'h044; wr_n = 1'b0; rd_n = 1'b0;
        idle(2);
        wr_n = 1'b1; rd_n = 1'b1;
        idle(4);
        rd_word(got); chk(got == 9'h022, "R8 read applied", got, 9'h022);
        rd_word(got); chk(got == 9'h033, "R8 order kept", got, 9'h033);
        rd_word(got); chk(got == 9'h044, "R8 write applied", got, 9'h044);
        chk(empty == 1'b1, "R8 occupancy unchanged by pair", empty, 1);

        // R9: retransmit
        do_reset();
        for (int i = 0; i < 5; i++) wr_word(W'(9'h010 + i));
        for (int i = 0; i < 3; i++) rd_word(got);
        @(negedge clk); rt_n = 1'b0;
        idle(2);
        rt_n = 1'b1;
        idle(4);
        for (int i = 0; i < 5; i++) begin
            rd_word(got);
            chk(got == W'(9'h010 + i), "R9 replayed word", got, 9'h010 + i);
        end
        chk(empty == 1'b1, "R9 empty after replay", empty, 1);

        // R10: reset mid-operation
        wr_word(9'h055); wr_word(9'h066);
        do_reset();
        chk(empty == 1'b1, "R10 empty after reset", empty, 1);

        idle(4);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule